// File: doc/BRIEF.md
# Receive Page Buffer Controller

This block places one incoming packet into a page of a byte-wide on-chip RAM and tells a host when the page holds a complete packet. The host arms a reception by writing a page number to the command register. The block then takes the next frame from a byte stream (valid, data, last) and writes it into the selected page in the same layout the sender used. After the final byte is in place, it raises a receive-done status bit. If the host has set the mask bit, the block also drives an interrupt line.

A frame starts with a source ID and a destination ID. A count byte follows, and the payload comes after it. The payload is always placed so that it ends at the top of its page, so the start offset comes straight from the count byte. The block has two packet formats, and a configuration bit decides whether the long format is accepted. In short mode each page is 256 bytes and the base address is the page number times 256. In long mode each page is 512 bytes and the base address is the page number times 512. The host can read any RAM byte through a separate read port while no frame is arriving. Line coding, token passing, CRC checking and the host bus protocol are handled elsewhere.

Top module: `rxpage_ctrl`

## Requirements
- R1: After reset, the status register (register 0, bit 0 = receive-done) reads 1. The config register (register 1), the mask register (register 2) and the page register (register 3) read 0, and `irq` is 0. Register reads return data one cycle after `reg_addr` is presented.
- R2: Writing register 0 is the enable-receive command. It clears receive-done on the next edge and latches `reg_wdata[PAGE_W-1:0]` as the target page, which reads back from register 3.
- R3: `irq` is a registered copy of (receive-done AND mask bit 0). When the mask bit is 0, `irq` stays low and the host must poll receive-done.
- R4: The first frame byte (source ID) goes to page offset 0, the second (destination ID) to offset 1 and the third (count byte) to offset 2. The page base is page×256 in short mode and page×512 in long mode (config bit 0 = 1).
- R5: For a short packet, the count byte holds v = 256−N, and the N payload bytes go to page offsets v through 255 in arrival order.
- R6: In long mode a count byte of 0 marks a long packet. The fourth byte, v = 512−N, goes to offset 3, and the payload goes to offsets v through 511. A count byte below 3, or in a long packet a fourth byte below 4, makes the frame invalid. In short mode a count byte of 0 is therefore invalid, and the frame is discarded with receive-done left at 0.
- R7: Receive-done returns to 1 only after a frame whose last byte (`rx_last` = 1) lands exactly at the final offset of the page. While the final byte has not yet arrived, status reads 0.
- R8: A frame that ends before the final offset is discarded, and so is one that carries bytes beyond it. Receive-done stays 0 and the next valid frame is still received into the same page.
- R9: A frame that arrives while receive-done is 1 is ignored. No RAM byte changes.
- R10: `host_rdata` returns the RAM byte at `host_raddr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command/status, 1 config, 2 mask, 3 page |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered register read data |
| irq | output | 1 | Interrupt, receive-done AND mask |
| rx_valid | input | 1 | Incoming frame byte valid |
| rx_data | input | 8 | Incoming frame byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| host_raddr | input | PAGE_W+9 | Host RAM read address |
| host_rdata | output | 8 | Registered host RAM read data |

## Verification
The assertions assume two things about the inputs. First, `rx_last` is only meaningful together with `rx_valid`. Second, the host does not write the command register while it relies on a frame that is still arriving. The assertions also assume the command-write decode is the only event that clears receive-done. The stimulus keeps to these assumptions in three ways. It drives one byte per cycle with `rx_last` only on the final valid byte. It issues register writes only while the stream is idle. It performs every RAM and status read between frames, when the receiver is waiting or skipping.

// File: rtl/rxpg_pkg.sv
package rxpg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_PAY  = 2'd2,
    ST_SKIP = 2'd3
  } rx_state_e;

  localparam logic [1:0] REG_CMD  = 2'd0;
  localparam logic [1:0] REG_CFG  = 2'd1;
  localparam logic [1:0] REG_MASK = 2'd2;
  localparam logic [1:0] REG_PAGE = 2'd3;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/rxpg_regs.sv
module rxpg_regs
  import rxpg_pkg::*;
#(
  parameter int PAGE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              frame_ok,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              done_q,
  output logic              long_q,
  output logic              mask_q,
  output logic [PAGE_W-1:0] page_q,
  output logic              cmd_hit,
  output logic              irq
);
  localparam int PAD_W = BYTE_W - PAGE_W;

  assign cmd_hit = reg_wr && (reg_addr == REG_CMD);

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q    <= 1'b1;
      long_q    <= 1'b0;
      mask_q    <= 1'b0;
      page_q    <= '0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      // command write wins over a completing frame in the same cycle
      if (cmd_hit) begin
        done_q <= 1'b0;
        page_q <= reg_wdata[PAGE_W-1:0];
      end else if (frame_ok) begin
        done_q <= 1'b1;
      end
      if (reg_wr && reg_addr == REG_CFG)  long_q <= reg_wdata[0];
      if (reg_wr && reg_addr == REG_MASK) mask_q <= reg_wdata[0];
      irq <= done_q & mask_q;
      case (reg_addr)
        REG_CMD:  reg_rdata <= {{(BYTE_W-1){1'b0}}, done_q};
        REG_CFG:  reg_rdata <= {{(BYTE_W-1){1'b0}}, long_q};
        REG_MASK: reg_rdata <= {{(BYTE_W-1){1'b0}}, mask_q};
        default:  reg_rdata <= {{PAD_W{1'b0}}, page_q};
      endcase
    end
  end
endmodule

// File: rtl/rxpg_frame.sv
module rxpg_frame
  import rxpg_pkg::*;
#(
  parameter int PAGE_W = 2,
  parameter int AW     = PAGE_W + 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_last,
  input  logic              armed,
  input  logic              long_en,
  input  logic [PAGE_W-1:0] page,
  input  logic              abort,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              frame_ok
);
  localparam logic [8:0] END_SHORT = 9'd255;
  localparam logic [8:0] END_LONG  = 9'd511;
  localparam logic [7:0] MIN_SHORT = 8'd3;
  localparam logic [7:0] MIN_LONG  = 8'd4;

  rx_state_e  state;
  logic [1:0] idx;
  logic [8:0] off;
  logic       lmode;
  logic       lframe;

  logic [8:0]    cur_off;
  logic [8:0]    end_off;
  logic          mode_c;
  logic          we_c;
  logic [AW-1:0] addr_c;

  always_comb begin
    case (state)
      ST_HDR:  cur_off = {7'd0, idx};
      ST_PAY:  cur_off = off;
      default: cur_off = '0;
    endcase
    end_off = lframe ? END_LONG : END_SHORT;
    mode_c  = (state == ST_IDLE) ? long_en : lmode;
    addr_c  = mode_c ? {page, cur_off} : {1'b0, page, cur_off[7:0]};
    we_c    = rx_valid && !abort &&
              (((state == ST_IDLE) && armed) || state == ST_HDR || state == ST_PAY);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      idx      <= '0;
      off      <= '0;
      lmode    <= 1'b0;
      lframe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      frame_ok <= 1'b0;
    end else begin
      wr_en    <= we_c;
      wr_addr  <= addr_c;
      wr_data  <= rx_data;
      frame_ok <= 1'b0;
      if (abort) begin
        if (rx_valid && rx_last)                 state <= ST_IDLE;
        else if (state != ST_IDLE || rx_valid)   state <= ST_SKIP;
        else                                     state <= ST_IDLE;
      end else if (rx_valid) begin
        case (state)
          ST_IDLE: begin
            lmode  <= long_en;
            lframe <= 1'b0;
            idx    <= 2'd1;
            if (rx_last)     state <= ST_IDLE;
            else if (armed)  state <= ST_HDR;
            else             state <= ST_SKIP;
          end
          ST_HDR: begin
            if (rx_last) begin
              state <= ST_IDLE;
            end else begin
              case (idx)
                2'd1: idx <= 2'd2;
                2'd2: begin
                  if (lmode && rx_data == 8'd0) begin
                    lframe <= 1'b1;
                    idx    <= 2'd3;
                  end else if (rx_data < MIN_SHORT) begin
                    state <= ST_SKIP;
                  end else begin
                    off   <= {1'b0, rx_data};
                    state <= ST_PAY;
                  end
                end
                default: begin
                  if (rx_data < MIN_LONG) begin
                    state <= ST_SKIP;
                  end else begin
                    off   <= {1'b0, rx_data};
                    state <= ST_PAY;
                  end
                end
              endcase
            end
          end
          ST_PAY: begin
            if (off == end_off) begin
              state    <= rx_last ? ST_IDLE : ST_SKIP;
              frame_ok <= rx_last;
            end else if (rx_last) begin
              state <= ST_IDLE;
            end else begin
              off <= off + 9'd1;
            end
          end
          default: begin
            if (rx_last) state <= ST_IDLE;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/rxpg_ram.sv
module rxpg_ram
  import rxpg_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [BYTE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxpage_ctrl.sv
module rxpage_ctrl
  import rxpg_pkg::*;
#(
  parameter int PAGE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic [PAGE_W+8:0] host_raddr,
  output logic [7:0]        host_rdata
);
  localparam int AW = PAGE_W + 9;

  logic              done_q;
  logic              long_q;
  logic              mask_q;
  logic [PAGE_W-1:0] page_q;
  logic              cmd_hit;
  logic              frame_ok;
  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  logic [7:0]        wr_data;

  rxpg_regs #(.PAGE_W(PAGE_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .frame_ok  (frame_ok),
    .reg_rdata (reg_rdata),
    .done_q    (done_q),
    .long_q    (long_q),
    .mask_q    (mask_q),
    .page_q    (page_q),
    .cmd_hit   (cmd_hit),
    .irq       (irq)
  );

  rxpg_frame #(.PAGE_W(PAGE_W), .AW(AW)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_last  (rx_last),
    .armed    (!done_q),
    .long_en  (long_q),
    .page     (page_q),
    .abort    (cmd_hit),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .frame_ok (frame_ok)
  );

  rxpg_ram #(.AW(AW)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (host_raddr),
    .rdata (host_rdata)
  );
endmodule

// File: rtl/rxpage_ctrl_chk.sv
module rxpage_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       done,
  input logic       mask_en,
  input logic       irq,
  input logic       frame_ok,
  input logic       ram_we,
  input logic       rx_valid,
  input logic       rx_last
);
  // R1
  reset_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> done);

  // R2
  cmd_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd0) |=> !done);

  // R3
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (done && mask_en) |=> irq);

  // R3
  irq_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && mask_en) |=> !irq);

  // R7
  done_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(frame_ok));

  // R7
  ok_on_last_chk: assert property (@(posedge clk) disable iff (rst)
    frame_ok |-> $past(rx_valid && rx_last));

  // R9
  no_write_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> $past(!done));
endmodule

bind rxpage_ctrl rxpage_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .done     (done_q),
  .mask_en  (mask_q),
  .irq      (irq),
  .frame_ok (frame_ok),
  .ram_we   (wr_en),
  .rx_valid (rx_valid),
  .rx_last  (rx_last)
);

// File: tb/rxpage_ctrl_tb.sv
module rxpage_ctrl_tb;
  localparam int PAGE_W = 2;
  localparam int AW = PAGE_W + 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic [1:0]    wr_addr = 2'd0;
  logic [1:0]    mon_addr = 2'd0;
  logic [1:0]    reg_addr;
  logic [7:0]    reg_wdata = 8'd0;
  logic [7:0]    reg_rdata;
  logic          irq;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_data = 8'd0;
  logic          rx_last = 1'b0;
  logic [AW-1:0] host_raddr = '0;
  logic [7:0]    host_rdata;

  assign reg_addr = reg_wr ? wr_addr : mon_addr;

  always #5 clk = ~clk;

  rxpage_ctrl #(.PAGE_W(PAGE_W)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .host_raddr(host_raddr), .host_rdata(host_rdata)
  );

  typedef struct {
    bit         is_reg;
    int         addr;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t      sbq[$];
  logic [7:0] fr[$];
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         mon_busy = 1'b0;

  task automatic exp_reg(input int a, input logic [7:0] v, input string tag);
    item_t it;
    it.is_reg = 1'b1; it.addr = a; it.exp = v; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic exp_ram(input int a, input logic [7:0] v, input string tag);
    item_t it;
    it.is_reg = 1'b0; it.addr = a; it.exp = v; it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor: pops expectations and compares against design reads
  initial begin
    item_t      it;
    logic [7:0] got;
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        mon_busy = 1'b1;
        it = sbq.pop_front();
        if (it.is_reg) mon_addr = it.addr[1:0];
        else           host_raddr = it.addr[AW-1:0];
        @(negedge clk);
        got = it.is_reg ? reg_rdata : host_rdata;
        n_cmp++;
        if (got !== it.exp) begin
          n_bad++;
          $display("FAIL %s %s addr %0d: got %02h expected %02h",
                   it.tag, it.is_reg ? "reg" : "ram", it.addr, got, it.exp);
        end
        mon_busy = 1'b0;
      end
    end
  end

  task automatic drain();
    while (sbq.size() > 0 || mon_busy) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    n_cmp++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s irq: got %b expected %b", tag, irq, e);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    drain();
    @(negedge clk);
    reg_wr = 1'b1; wr_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_range(input int from, input int upto, input bit last_at_end);
    drain();
    for (int i = from; i <= upto; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = fr[i];
      rx_last  = last_at_end && (i == upto);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_all();
    send_range(0, fr.size() - 1, 1'b1);
  endtask

  task automatic build_short(input logic [7:0] sid, input logic [7:0] did,
                             input int n, input logic [7:0] seed);
    fr.delete();
    fr.push_back(sid); fr.push_back(did); fr.push_back(8'(256 - n));
    for (int k = 0; k < n; k++) fr.push_back(8'(seed + k * 3));
  endtask

  task automatic build_long(input logic [7:0] sid, input logic [7:0] did,
                            input int n, input logic [7:0] seed);
    fr.delete();
    fr.push_back(sid); fr.push_back(did); fr.push_back(8'd0); fr.push_back(8'(512 - n));
    for (int k = 0; k < n; k++) fr.push_back(8'(seed + k * 5));
  endtask

  // expected placement of fr in a page: header at 0.., payload ending at page top
  task automatic exp_frame(input int base, input bit lng, input int n, input string tag);
    int hdr;
    int top;
    hdr = lng ? 4 : 3;
    top = lng ? 512 : 256;
    for (int i = 0; i < fr.size(); i++) begin
      if (i < hdr) exp_ram(base + i, fr[i], tag);
      else         exp_ram(base + top - n + (i - hdr), fr[i], tag);
    end
  endtask

  logic [7:0] keep[$];

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_irq(1'b0, "R1");
    exp_reg(0, 8'd1, "R1"); exp_reg(1, 8'd0, "R1");
    exp_reg(2, 8'd0, "R1"); exp_reg(3, 8'd0, "R1");
    drain();

    // R3 mask on while done=1 raises irq
    wr(2'd2, 8'd1);
    chk_irq(1'b1, "R3");

    // R2 arm page 1 (short mode, base 256)
    wr(2'd0, 8'd1);
    exp_reg(0, 8'd0, "R2"); exp_reg(3, 8'd1, "R2");
    drain();
    chk_irq(1'b0, "R3");

    // R4 R5 R10 short packet into page 1
    build_short(8'h11, 8'h22, 5, 8'h40);
    send_all();
    exp_reg(0, 8'd1, "R7");
    exp_frame(256, 1'b0, 5, "R4/R5/R10");
    drain();
    chk_irq(1'b1, "R3");

    // R9 frame while done=1 is ignored: page keeps old content
    keep = fr;
    build_short(8'h77, 8'h66, 5, 8'h90);
    send_all();
    fr = keep;
    exp_frame(256, 1'b0, 5, "R9");
    exp_reg(0, 8'd1, "R9");
    drain();

    // R3 mask off: irq low while done still 1
    wr(2'd2, 8'd0);
    chk_irq(1'b0, "R3");
    exp_reg(0, 8'd1, "R3");
    drain();

    // R8 truncated and overrun frames on page 2
    wr(2'd0, 8'd2);
    build_short(8'h01, 8'h02, 4, 8'h10);
    send_range(0, 4, 1'b1);
    exp_reg(0, 8'd0, "R8");
    drain();
    build_short(8'h03, 8'h04, 2, 8'h20);
    fr.push_back(8'hEE);
    send_all();
    exp_reg(0, 8'd0, "R8");
    drain();

    // R7 status stays 0 until final byte, then R8 recovery
    build_short(8'h05, 8'h06, 3, 8'h30);
    send_range(0, fr.size() - 2, 1'b0);
    exp_reg(0, 8'd0, "R7");
    drain();
    send_range(fr.size() - 1, fr.size() - 1, 1'b1);
    exp_reg(0, 8'd1, "R8");
    exp_frame(512, 1'b0, 3, "R4/R5");
    drain();

    // R6 short mode: count byte 0 is invalid
    wr(2'd0, 8'd3);
    fr.delete();
    fr.push_back(8'h0A); fr.push_back(8'h0B); fr.push_back(8'h00);
    fr.push_back(8'h05); fr.push_back(8'h01); fr.push_back(8'h02);
    send_all();
    exp_reg(0, 8'd0, "R6");
    drain();

    // R6 long mode: page 1 at base 512, N = 260
    wr(2'd1, 8'd1);
    exp_reg(1, 8'd1, "R6");
    drain();
    wr(2'd0, 8'd1);
    build_long(8'hA1, 8'hB2, 260, 8'h07);
    send_all();
    exp_reg(0, 8'd1, "R6");
    exp_frame(512, 1'b1, 260, "R6");
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule